// File: doc/BRIEF.md
# Multi-Mode Shift and Rotate Unit

This block moves the bits of an 8-bit data word by a distance of 0 to 7 places. A 3-bit operation code selects the mode. The modes are:

- a plain shift that fills the vacated positions with zeros;
- an arithmetic shift that copies an edge bit of the original word into the vacated positions;
- a rotate that carries the bits leaving one end back in at the other.

Each mode works in either direction. The block is purely combinational, with no clock and no flags. It sits in the execute path of a datapath, where the result is consumed in the same cycle in which the operands are presented.

The left arithmetic mode copies the original least significant bit into the vacated low positions. It is therefore the mirror image of the right arithmetic mode, which copies the original most significant bit into the vacated high positions. The two unused operation codes return the operand unchanged.

Top module: `shiftrot_unit`

## Requirements
- R1: With opCode 3'b000 (logical left), each result bit i equals operand bit i-shiftAmt, and the result is 0 where i < shiftAmt. For example, 10010101 shifted by 2 gives 01010100.
- R2: With opCode 3'b001 (logical right), each result bit i equals operand bit i+shiftAmt, and the result is 0 where i+shiftAmt > 7. For example, 10010101 shifted by 3 gives 00010010.
- R3: With opCode 3'b010 (arithmetic left), the bits move as in R1, but every vacated low position takes the value of operand bit 0. For example, 10010101 shifted by 3 gives 10101111.
- R4: With opCode 3'b011 (arithmetic right), the bits move as in R2, but every vacated high position takes the value of operand bit 7. For example, 10010101 shifted by 2 gives 11100101.
- R5: With opCode 3'b100 (rotate left), result bit i equals operand bit (i-shiftAmt) mod 8. For example, 10100011 rotated by 2 gives 10001110.
- R6: With opCode 3'b101 (rotate right), result bit i equals operand bit (i+shiftAmt) mod 8. For example, 10100011 rotated by 2 gives 11101000.
- R7: With opCode 3'b110 or 3'b111, the result equals the operand for every shiftAmt.
- R8: With shiftAmt 0, the result equals the operand under every opCode.
- R9: The result depends only on the present inputs. It follows an input change within the same clock cycle, without any clock edge, and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 8 | Data word to be shifted or rotated |
| opCode | input | 3 | Operation select (encoding in R1 to R7) |
| shiftAmt | input | 3 | Distance in bit positions, 0 to 7 |
| result | output | 8 | Shifted or rotated word |

## Verification
Every combination of operand, code and distance is applied and compared with a bit-by-bit loop model. This sweep separates zero fill from edge-bit fill and from wraparound in each direction.

Words whose bit 0 and bit 7 differ, such as 10010101, make a wrong fill source visible in the arithmetic modes. This matters most for the left arithmetic mode, because it must copy bit 0 rather than insert a zero.

The worked examples above are also applied by name. In addition, two inputs are changed within a single half period, which shows that the output settles without a clock.

// File: rtl/shiftrot_pkg.sv
package shiftrot_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_LOG = 3'd0,
    OP_SHR_LOG = 3'd1,
    OP_SHL_ARI = 3'd2,
    OP_SHR_ARI = 3'd3,
    OP_ROT_L   = 3'd4,
    OP_ROT_R   = 3'd5,
    OP_PASS_A  = 3'd6,
    OP_PASS_B  = 3'd7
  } opcode_e;

  // Source of the bits entering the vacated positions of the right shifter.
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_EDGE = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic  mirror;  // bit-reverse on the way in and out: left-hand operations
    fill_e fill;
    logic  bypass;  // forward the operand untouched
  } ctrl_t;

endpackage

// File: rtl/shiftrot_ctrl.sv
module shiftrot_ctrl
  import shiftrot_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '{mirror: 1'b0, fill: FILL_ZERO, bypass: 1'b0};
    case (opcode_e'(opCode))
      OP_SHL_LOG: ctrl = '{mirror: 1'b1, fill: FILL_ZERO, bypass: 1'b0};
      OP_SHR_LOG: ctrl = '{mirror: 1'b0, fill: FILL_ZERO, bypass: 1'b0};
      OP_SHL_ARI: ctrl = '{mirror: 1'b1, fill: FILL_EDGE, bypass: 1'b0};
      OP_SHR_ARI: ctrl = '{mirror: 1'b0, fill: FILL_EDGE, bypass: 1'b0};
      OP_ROT_L:   ctrl = '{mirror: 1'b1, fill: FILL_WRAP, bypass: 1'b0};
      OP_ROT_R:   ctrl = '{mirror: 1'b0, fill: FILL_WRAP, bypass: 1'b0};
      default:    ctrl = '{mirror: 1'b0, fill: FILL_ZERO, bypass: 1'b1};
    endcase
  end

endmodule

// File: rtl/shiftrot_mirror.sv
module shiftrot_mirror #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] flipped;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign flipped[i] = din[WIDTH-1-i];
  end

  assign dout = en ? flipped : din;

endmodule

// File: rtl/shiftrot_rstage.sv
module shiftrot_rstage
  import shiftrot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DIST  = 1
) (
  input  logic             en,
  input  fill_e            fill,
  input  logic             edgeBit,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic             fillBit;
  logic [WIDTH-1:0] shifted;

  assign fillBit = (fill == FILL_EDGE) ? edgeBit : 1'b0;

  always_comb begin
    if (fill == FILL_WRAP) shifted = {din[DIST-1:0], din[WIDTH-1:DIST]};
    else                   shifted = {{DIST{fillBit}}, din[WIDTH-1:DIST]};
  end

  assign dout = en ? shifted : din;

endmodule

// File: rtl/shiftrot_datapath.sv
module shiftrot_datapath
  import shiftrot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] shiftAmt,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] stageBus [AMT_W+1];
  logic [WIDTH-1:0] unmirrored;
  logic             edgeBit;

  shiftrot_mirror #(.WIDTH(WIDTH)) u_mirror_in (
    .en   (ctrl.mirror),
    .din  (operand),
    .dout (stageBus[0])
  );

  // Edge bit of the word entering the shifter: bit 7 for a right shift,
  // original bit 0 once the word has been mirrored for a left shift.
  assign edgeBit = stageBus[0][WIDTH-1];

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shiftrot_rstage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
      .en      (shiftAmt[k]),
      .fill    (ctrl.fill),
      .edgeBit (edgeBit),
      .din     (stageBus[k]),
      .dout    (stageBus[k+1])
    );
  end

  shiftrot_mirror #(.WIDTH(WIDTH)) u_mirror_out (
    .en   (ctrl.mirror),
    .din  (stageBus[AMT_W]),
    .dout (unmirrored)
  );

  assign result = ctrl.bypass ? operand : unmirrored;

endmodule

// File: rtl/shiftrot_unit.sv
module shiftrot_unit
  import shiftrot_pkg::*;
#(
  parameter int  WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [OP_W-1:0]  opCode,
  input  logic [AMT_W-1:0] shiftAmt,
  output logic [WIDTH-1:0] result
);

  ctrl_t ctrl;

  shiftrot_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  shiftrot_datapath #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dp (
    .ctrl     (ctrl),
    .operand  (operand),
    .shiftAmt (shiftAmt),
    .result   (result)
  );

endmodule

// File: rtl/shiftrot_unit_checker.sv
module shiftrot_unit_checker #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] operand,
  input logic [2:0]       opCode,
  input logic [AMT_W-1:0] shiftAmt,
  input logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] lowMask;
  logic [WIDTH-1:0] highMask;
  logic             known;

  assign lowMask  = (WIDTH'(1) << shiftAmt) - WIDTH'(1);
  assign highMask = ~({WIDTH{1'b1}} >> shiftAmt);
  assign known    = !$isunknown({operand, opCode, shiftAmt, result});

  always_comb begin
    if (known) begin
      assert_zero_dist_identity_R8: assert (shiftAmt != '0 || result == operand)
        else $error("zero distance changed the word");
      assert_spare_codes_pass_R7: assert (opCode[2:1] != 2'b11 || result == operand)
        else $error("spare code altered the word");
      assert_shl_low_zero_R1: assert (opCode != 3'd0 || (result & lowMask) == '0)
        else $error("logical left fill not zero");
      assert_shr_high_zero_R2: assert (opCode != 3'd1 || (result & highMask) == '0)
        else $error("logical right fill not zero");
      assert_sla_keeps_lsb_R3: assert (opCode != 3'd2 || result[0] == operand[0])
        else $error("arithmetic left lost bit 0");
      assert_sra_keeps_msb_R4: assert (opCode != 3'd3 || result[WIDTH-1] == operand[WIDTH-1])
        else $error("arithmetic right lost sign");
      assert_rotl_popcount_R5: assert (opCode != 3'd4 || $countones(result) == $countones(operand))
        else $error("rotate left lost bits");
      assert_rotr_popcount_R6: assert (opCode != 3'd5 || $countones(result) == $countones(operand))
        else $error("rotate right lost bits");
    end
  end

endmodule

bind shiftrot_unit shiftrot_unit_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .operand  (operand),
  .opCode   (opCode),
  .shiftAmt (shiftAmt),
  .result   (result)
);

// File: tb/shiftrot_unit_tb.sv
module shiftrot_unit_tb;

  localparam int WIDTH = 8;
  localparam int AMT_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] operand = '0;
  logic [2:0]       opCode = '0;
  logic [AMT_W-1:0] shiftAmt = '0;
  logic [WIDTH-1:0] result;

  int vecCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shiftrot_unit #(.WIDTH(WIDTH)) u_dut (
    .operand  (operand),
    .opCode   (opCode),
    .shiftAmt (shiftAmt),
    .result   (result)
  );

  function automatic logic [WIDTH-1:0] refModel(logic [WIDTH-1:0] x, logic [2:0] op, int amt);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      int lo = i - amt;
      int hi = i + amt;
      case (op)
        3'd0:    r[i] = (lo >= 0) ? x[lo] : 1'b0;
        3'd1:    r[i] = (hi < WIDTH) ? x[hi] : 1'b0;
        3'd2:    r[i] = (lo >= 0) ? x[lo] : x[0];
        3'd3:    r[i] = (hi < WIDTH) ? x[hi] : x[WIDTH-1];
        3'd4:    r[i] = x[(lo + WIDTH) % WIDTH];
        3'd5:    r[i] = x[hi % WIDTH];
        default: r[i] = x[i];
      endcase
    end
    return r;
  endfunction

  function automatic string reqOf(logic [2:0] op, int amt);
    if (amt == 0) return "R8";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [WIDTH-1:0] expVal);
    vecCount++;
    if (result !== expVal) begin
      failCount++;
      $display("FAIL %s op=%0d amt=%0d operand=%b actual=%b expected=%b",
               req, opCode, shiftAmt, operand, result, expVal);
    end
  endtask

  // Drive after a falling edge, sample 1 ns later, before the next rising edge.
  task automatic apply(logic [WIDTH-1:0] x, logic [2:0] op, int amt, string req, logic [WIDTH-1:0] expVal);
    @(negedge clk);
    operand  = x;
    opCode   = op;
    shiftAmt = AMT_W'(amt);
    #1;
    check(req, expVal);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R8", 8'h00);  // reset state: zero word, code 0, distance 0
    rst = 1'b0;

    // Worked examples
    apply(8'b10010101, 3'd0, 2, "R1", 8'b01010100);
    apply(8'b10010101, 3'd1, 3, "R2", 8'b00010010);
    apply(8'b10010101, 3'd2, 3, "R3", 8'b10101111);
    apply(8'b10010101, 3'd3, 2, "R4", 8'b11100101);
    apply(8'b10100011, 3'd4, 2, "R5", 8'b10001110);
    apply(8'b10100011, 3'd5, 2, "R6", 8'b11101000);
    apply(8'b10100011, 3'd6, 5, "R7", 8'b10100011);
    apply(8'b01011010, 3'd7, 7, "R7", 8'b01011010);
    apply(8'b01101100, 3'd2, 7, "R3", 8'b00000000);
    apply(8'b10000001, 3'd2, 7, "R3", 8'b11111111);

    // R9: two input changes inside one half period, no clock edge between
    @(negedge clk);
    operand = 8'b00000001; opCode = 3'd4; shiftAmt = 3'd7;
    #0.5;
    check("R9", 8'b10000000);
    operand = 8'b00000011; opCode = 3'd5; shiftAmt = 3'd1;
    #0.5;
    check("R9", 8'b10000001);

    // Exhaustive sweep
    for (int op = 0; op < 8; op++) begin
      for (int amt = 0; amt < WIDTH; amt++) begin
        for (int x = 0; x < (1 << WIDTH); x++) begin
          apply(WIDTH'(x), 3'(op), amt, reqOf(3'(op), amt), refModel(WIDTH'(x), 3'(op), amt));
        end
      end
    end

    finishRun();
  end

endmodule